// File: doc/BRIEF.md
# Gated Retriggerable One-Shot Pulse Generator

This block is a clocked one-shot. It raises a pulse output for a programmable number of clock cycles when one of three gated trigger conditions is seen on its asynchronous inputs. There is a falling-edge start input, a rising-edge start input and an active-low clear input. The clear input doubles as a rising-edge start. A complementary output runs beside the pulse output. The pulse length comes from a 16-bit width input, not from analog timing parts. A trigger edge that arrives while a pulse is running restarts the full width. Steady retriggering therefore holds the output high indefinitely.

Each input first passes through a two-flop synchroniser. Edges are then found by comparing the synchronised sample with the one taken a cycle earlier. Holding the clear input low drops the pulse and blocks every trigger. A retrigger that comes too soon after the last accepted trigger is discarded; the minimum spacing is a parameter. A synchronous system reset returns the block to idle whatever the clear input is doing. An internal settle counter makes sure that the input levels present when reset is released are never taken as edges.

The controller has three named states. ST_IDLE waits for an accepted trigger. ST_PULSE drives the output and counts the width down. ST_HELD is entered while the synchronised clear is low. The transitions are:
- IDLE to PULSE on an accepted trigger with a non-zero width.
- PULSE to PULSE (reload) on an accepted retrigger with a non-zero width.
- PULSE to IDLE when the count is exhausted, or on an accepted trigger with width zero.
- Any state to HELD while clear is low.
- HELD to PULSE when the clear rises as a valid trigger with a non-zero width.
- HELD to IDLE otherwise once clear is high.

Top module: `oneshot_retrig`

## Requirements
- R1: A falling edge on `trig_fall_i` starts a pulse only if `trig_rise_i` is high and `clr_n_i` is high at the sample where the fall is seen; otherwise it starts nothing.
- R2: A rising edge on `trig_rise_i` starts a pulse only if `trig_fall_i` is low and `clr_n_i` is high at that sample; otherwise it starts nothing.
- R3: A rising edge on `clr_n_i` starts a pulse only if `trig_fall_i` is low and `trig_rise_i` is high at that sample; otherwise it starts nothing.
- R4: A low level on `clr_n_i` that is first captured at clock edge E drives `pulse_o` low and `pulse_n_o` high right after edge E+2. It ends any running pulse. While the synchronised clear stays low, every trigger edge is ignored.
- R5: An input change first captured at edge E that forms an accepted trigger with width W > 0 makes `pulse_o` high right after edge E+2. `pulse_o` then stays high for exactly W clock cycles unless it is retriggered, cleared or reset.
- R6: `pulse_n_o` is always the inverse of `pulse_o`.
- R7: An accepted trigger during a pulse reloads the full width, counted from that trigger. Triggers spaced by at least the minimum gap therefore keep `pulse_o` continuously high.
- R8: During a pulse, a trigger edge is accepted only if at least `MIN_GAP` clock cycles (default 4) have passed since the last accepted trigger, counted between capture edges. Closer edges are ignored and do not restart this spacing count. When no pulse is running, triggers are always accepted.
- R9: `width_i` is sampled only at the cycle a trigger is accepted. An accepted trigger with width zero produces no pulse, and if a pulse is running it ends that pulse.
- R10: Static input levels never start a pulse. Input changes that do not form a valid trigger leave a running pulse to end at its programmed time.
- R11: After `rst` is released, the levels present on the inputs are never treated as edges: no pulse appears until a real input transition occurs.
- R12: While `rst` is high, `pulse_o` is low and `pulse_n_o` is high one cycle later, independent of `clr_n_i`. A pulse in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| trig_fall_i | input | 1 | Asynchronous falling-edge trigger input |
| trig_rise_i | input | 1 | Asynchronous rising-edge trigger input |
| clr_n_i | input | 1 | Asynchronous active-low clear, also a rising-edge trigger |
| width_i | input | WIDTH_W (16) | Pulse width in clock cycles, sampled at an accepted trigger |
| pulse_o | output | 1 | Pulse output, high while a pulse runs |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
The hardest situation to reach is the retrigger spacing boundary. The stimulus has to place one edge under the minimum gap and a later one exactly at it, and show that the rejected edge did not restart the spacing count. Only the total number of high cycles reveals this. The bench drives the rising-edge input on exact falling-clock counts (spacings 2, 4 and 2+2) and compares pulse totals worked out from the width and gap arithmetic. Trigger edges hidden inside a held clear, and a release from reset with trigger-enabling levels already present, are reached the same way: the pin sequence is scripted around the known two-edge capture latency.

// File: rtl/oneshot_pkg.sv
`timescale 1ns/1ps
package oneshot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HELD  = 2'd2
    } os_state_e;

    // Bit positions of the trigger inputs inside the detector's vector
    localparam int unsigned IDX_FALL = 0;
    localparam int unsigned IDX_RISE = 1;
    localparam int unsigned IDX_CLR  = 2;
    localparam int unsigned N_TRIG   = 3;

    function automatic int unsigned gap_bits(input int unsigned gap);
        return (gap < 2) ? 1 : $clog2(gap + 1);
    endfunction

endpackage

// File: rtl/os_sync.sv
`timescale 1ns/1ps
module os_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/os_trig_detect.sv
`timescale 1ns/1ps
module os_trig_detect
    import oneshot_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_in_i,
    input  logic rise_in_i,
    input  logic clr_n_in_i,
    output logic valid_o,
    output logic clr_lvl_o,
    output logic fire_o
);

    localparam int unsigned SETTLE = STAGES + 1;
    localparam int unsigned CNT_W  = $clog2(SETTLE + 1);

    logic [N_TRIG-1:0] raw;
    logic [N_TRIG-1:0] cur;
    logic [N_TRIG-1:0] prev;
    logic [CNT_W-1:0]  settle_cnt;
    logic              fire_fall, fire_rise, fire_clr;

    assign raw[IDX_FALL] = fall_in_i;
    assign raw[IDX_RISE] = rise_in_i;
    assign raw[IDX_CLR]  = clr_n_in_i;

    generate
        for (genvar gi = 0; gi < N_TRIG; gi++) begin : g_sync
            os_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
                .clk (clk),
                .rst (rst),
                .d_i (raw[gi]),
                .q_o (cur[gi])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= cur;
    end

    // Edge detection only once prev holds a sample taken after reset
    always_ff @(posedge clk) begin
        if (rst)                              settle_cnt <= '0;
        else if (settle_cnt != CNT_W'(SETTLE)) settle_cnt <= settle_cnt + CNT_W'(1);
    end

    assign valid_o = (settle_cnt == CNT_W'(SETTLE));

    always_comb begin
        fire_fall = prev[IDX_FALL] & ~cur[IDX_FALL] & cur[IDX_RISE] & cur[IDX_CLR];
        fire_rise = ~prev[IDX_RISE] & cur[IDX_RISE] & ~cur[IDX_FALL] & cur[IDX_CLR];
        fire_clr  = ~prev[IDX_CLR] & cur[IDX_CLR] & ~cur[IDX_FALL] & cur[IDX_RISE];
    end

    assign fire_o    = valid_o & (fire_fall | fire_rise | fire_clr);
    assign clr_lvl_o = cur[IDX_CLR];

endmodule

// File: rtl/os_pulse_fsm.sv
`timescale 1ns/1ps
module os_pulse_fsm
    import oneshot_pkg::*;
#(
    parameter int unsigned WIDTH_W = 16,
    parameter int unsigned MIN_GAP = 4,
    localparam int unsigned GAP_W  = gap_bits(MIN_GAP)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_i,
    input  logic               clr_lvl_i,
    input  logic               fire_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               pulse_o,
    output logic               pulse_n_o,
    output logic [WIDTH_W-1:0] remain_o,
    output logic [GAP_W-1:0]   gap_o
);

    os_state_e          state, state_d;
    logic [WIDTH_W-1:0] remain, remain_d;
    logic [GAP_W-1:0]   gap_cnt;
    logic               clear, gap_sat, accept, width_nz;

    assign clear    = valid_i & ~clr_lvl_i;
    assign gap_sat  = (gap_cnt == GAP_W'(MIN_GAP));
    assign accept   = fire_i & ((state != ST_PULSE) | gap_sat);
    assign width_nz = (width_i != '0);

    always_comb begin
        state_d  = state;
        remain_d = remain;
        unique case (state)
            ST_IDLE: begin
                if (clear) begin
                    state_d = ST_HELD;
                end else if (accept && width_nz) begin
                    state_d  = ST_PULSE;
                    remain_d = width_i - WIDTH_W'(1);
                end
            end
            ST_PULSE: begin
                if (clear) begin
                    state_d  = ST_HELD;
                    remain_d = '0;
                end else if (accept) begin
                    if (width_nz) remain_d = width_i - WIDTH_W'(1);
                    else          state_d  = ST_IDLE;
                end else if (remain == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    remain_d = remain - WIDTH_W'(1);
                end
            end
            ST_HELD: begin
                if (!clear) begin
                    if (accept && width_nz) begin
                        state_d  = ST_PULSE;
                        remain_d = width_i - WIDTH_W'(1);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            remain <= '0;
        end else begin
            state  <= state_d;
            remain <= remain_d;
        end
    end

    // Spacing counter since the last accepted trigger, saturating
    always_ff @(posedge clk) begin
        if (rst)           gap_cnt <= GAP_W'(MIN_GAP);
        else if (accept)   gap_cnt <= GAP_W'(1);
        else if (!gap_sat) gap_cnt <= gap_cnt + GAP_W'(1);
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_o   <= 1'b0;
            pulse_n_o <= 1'b1;
        end else begin
            pulse_o   <= (state_d == ST_PULSE);
            pulse_n_o <= (state_d != ST_PULSE);
        end
    end

    assign remain_o = remain;
    assign gap_o    = gap_cnt;

endmodule

// File: rtl/oneshot_retrig.sv
`timescale 1ns/1ps
module oneshot_retrig
    import oneshot_pkg::*;
#(
    parameter int unsigned WIDTH_W     = 16,
    parameter int unsigned MIN_GAP     = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned GAP_W      = gap_bits(MIN_GAP)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig_fall_i,
    input  logic               trig_rise_i,
    input  logic               clr_n_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               pulse_o,
    output logic               pulse_n_o
);

    logic               det_valid;
    logic               clr_lvl;
    logic               fire;
    logic [WIDTH_W-1:0] remain;
    logic [GAP_W-1:0]   gap_cnt;

    os_trig_detect #(.STAGES(SYNC_STAGES)) u_detect (
        .clk        (clk),
        .rst        (rst),
        .fall_in_i  (trig_fall_i),
        .rise_in_i  (trig_rise_i),
        .clr_n_in_i (clr_n_i),
        .valid_o    (det_valid),
        .clr_lvl_o  (clr_lvl),
        .fire_o     (fire)
    );

    os_pulse_fsm #(.WIDTH_W(WIDTH_W), .MIN_GAP(MIN_GAP)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (det_valid),
        .clr_lvl_i (clr_lvl),
        .fire_i    (fire),
        .width_i   (width_i),
        .pulse_o   (pulse_o),
        .pulse_n_o (pulse_n_o),
        .remain_o  (remain),
        .gap_o     (gap_cnt)
    );

endmodule

// File: rtl/oneshot_retrig_chk.sv
`timescale 1ns/1ps
module oneshot_retrig_chk
    import oneshot_pkg::*;
#(
    parameter int unsigned WIDTH_W = 16,
    parameter int unsigned MIN_GAP = 4,
    localparam int unsigned GAP_W  = gap_bits(MIN_GAP)
) (
    input logic               clk,
    input logic               rst,
    input logic               pulse_o,
    input logic               pulse_n_o,
    input logic               fire,
    input logic               det_valid,
    input logic               clr_lvl,
    input logic [WIDTH_W-1:0] width_i,
    input logic [WIDTH_W-1:0] remain,
    input logic [GAP_W-1:0]   gap_cnt
);

    logic gap_ok;
    assign gap_ok = (gap_cnt >= GAP_W'(MIN_GAP));

    assert_complement_R6: assert property (@(posedge clk) disable iff (rst)
        pulse_o != pulse_n_o);

    assert_sync_reset_R12: assert property (@(posedge clk)
        rst |=> (!pulse_o && pulse_n_o));

    assert_no_fire_unsettled_R11: assert property (@(posedge clk) disable iff (rst)
        !det_valid |-> !fire);

    assert_clear_drops_R4: assert property (@(posedge clk) disable iff (rst)
        (det_valid && !clr_lvl) |=> !pulse_o);

    assert_close_edge_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (pulse_o && fire && !gap_ok && clr_lvl && remain != '0)
        |=> (pulse_o && remain == $past(remain) - WIDTH_W'(1)));

    assert_retrig_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (fire && clr_lvl && width_i != '0 && (!pulse_o || gap_ok))
        |=> (pulse_o && remain == $past(width_i) - WIDTH_W'(1)));

    assert_zero_width_R9: assert property (@(posedge clk) disable iff (rst)
        (fire && clr_lvl && width_i == '0 && (!pulse_o || gap_ok)) |=> !pulse_o);

    assert_pulse_ends_R5: assert property (@(posedge clk) disable iff (rst)
        (pulse_o && remain == '0 && !fire && clr_lvl) |=> !pulse_o);

    assert_pulse_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (pulse_o && remain != '0 && !fire && clr_lvl) |=> pulse_o);

endmodule

bind oneshot_retrig oneshot_retrig_chk #(.WIDTH_W(WIDTH_W), .MIN_GAP(MIN_GAP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pulse_o   (pulse_o),
    .pulse_n_o (pulse_n_o),
    .fire      (fire),
    .det_valid (det_valid),
    .clr_lvl   (clr_lvl),
    .width_i   (width_i),
    .remain    (remain),
    .gap_cnt   (gap_cnt)
);

// File: tb/oneshot_retrig_tb_top.sv
`timescale 1ns/1ps
module oneshot_retrig_tb_top;

    localparam int WIDTH_W = 16;
    localparam int MIN_GAP = 4;
    localparam int CLK_NS  = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               pin_a = 1'b0;
    logic               pin_b = 1'b1;
    logic               pin_rd = 1'b1;
    logic [WIDTH_W-1:0] width = 16'd5;
    logic               pulse_o, pulse_n_o;

    int    checks = 0;
    int    errors = 0;
    int    hi_total = 0;
    bit    done = 1'b0;
    string cur_tag = "R12";

    // behavioural reference state
    bit qa[$];
    bit qb[$];
    bit qr[$];
    bit m_pulse = 1'b0;
    int m_rem = 0;
    int m_since = 1000;

    always #(CLK_NS/2) clk = ~clk;

    oneshot_retrig #(.WIDTH_W(WIDTH_W), .MIN_GAP(MIN_GAP), .SYNC_STAGES(2)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .trig_fall_i (pin_a),
        .trig_rise_i (pin_b),
        .clr_n_i     (pin_rd),
        .width_i     (width),
        .pulse_o     (pulse_o),
        .pulse_n_o   (pulse_n_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model: a level reaches the decision two edges after capture
    always @(posedge clk) begin
        if (rst) begin
            qa.delete(); qb.delete(); qr.delete();
            m_pulse = 1'b0; m_rem = 0; m_since = 1000;
        end else begin
            if (qa.size() >= 3) begin
                int n;
                bit ca, pa, cb, pb, cr, pr, fire, acc;
                n = qa.size();
                ca = qa[n-2]; pa = qa[n-3];
                cb = qb[n-2]; pb = qb[n-3];
                cr = qr[n-2]; pr = qr[n-3];
                fire = (pa && !ca && cb && cr) || (!pb && cb && !ca && cr) ||
                       (!pr && cr && !ca && cb);
                acc = fire && (!m_pulse || m_since >= MIN_GAP);
                if (acc) m_since = 1;
                else if (m_since < 1000) m_since++;
                if (!cr) m_pulse = 1'b0;
                else if (acc) begin
                    if (width != 0) begin m_pulse = 1'b1; m_rem = int'(width) - 1; end
                    else m_pulse = 1'b0;
                end else if (m_pulse) begin
                    if (m_rem == 0) m_pulse = 1'b0;
                    else m_rem--;
                end
            end else if (m_since < 1000) m_since++;
            qa.push_back(pin_a); qb.push_back(pin_b); qr.push_back(pin_rd);
            if (qa.size() > 4) begin
                void'(qa.pop_front()); void'(qb.pop_front()); void'(qr.pop_front());
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (pulse_o) hi_total++;
        chk(cur_tag, int'(pulse_o), int'(m_pulse));
        chk("R6", int'(pulse_n_o), int'(!m_pulse));
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one rising edge on the rise input, two cycles long in total
    task automatic b_edge();
        pin_b = 1'b1; tick(1);
        pin_b = 1'b0; tick(1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 60000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        int base;
        // R12 reset state, with trigger-enabling levels on the pins
        tick(5);
        // R11 release with B high, A low, RD high: no edge must be seen
        cur_tag = "R11";
        base = hi_total;
        rst = 1'b0;
        tick(20);
        chk("R11", hi_total - base, 0);
        pin_b = 1'b0; tick(5);

        // R2 and R5: rising edge on B with A low
        cur_tag = "R2"; width = 16'd5; base = hi_total;
        b_edge(); tick(30);
        chk("R2", hi_total - base, 5);
        chk("R5", hi_total - base, int'(width));

        // R2 gating: A high blocks
        pin_a = 1'b1; tick(5);
        base = hi_total; b_edge(); tick(20);
        chk("R2", hi_total - base, 0);

        // R1: A fall with B high
        cur_tag = "R1";
        pin_b = 1'b1; tick(5);
        width = 16'd7; base = hi_total;
        pin_a = 1'b0; tick(30);
        chk("R1", hi_total - base, 7);
        // R1 gating: B low blocks
        pin_b = 1'b0; tick(1); pin_a = 1'b1; tick(5);
        base = hi_total; pin_a = 1'b0; tick(20);
        chk("R1", hi_total - base, 0);

        // R3: clear rises with A low, B high
        cur_tag = "R3";
        pin_a = 1'b1; tick(1); pin_b = 1'b1; tick(1);
        pin_rd = 1'b0; tick(3); pin_a = 1'b0; tick(5);
        width = 16'd6; base = hi_total;
        pin_rd = 1'b1; tick(30);
        chk("R3", hi_total - base, 6);
        // R3 gating: A high blocks
        pin_a = 1'b1; tick(2); pin_rd = 1'b0; tick(5);
        base = hi_total; pin_rd = 1'b1; tick(20);
        chk("R3", hi_total - base, 0);
        pin_b = 1'b0; tick(1); pin_a = 1'b0; tick(5);

        // R7: retrigger 6 cycles later reloads full width: 6 + 10
        cur_tag = "R7"; width = 16'd10; base = hi_total;
        b_edge(); tick(4); b_edge(); tick(40);
        chk("R7", hi_total - base, 16);

        // R8: spacing 2 ignored
        cur_tag = "R8"; base = hi_total;
        b_edge(); b_edge(); tick(40);
        chk("R8", hi_total - base, 10);
        // R8: spacing exactly MIN_GAP accepted: 4 + 10
        base = hi_total;
        b_edge(); tick(2); b_edge(); tick(40);
        chk("R8", hi_total - base, 14);
        // R8: rejected edge at 2 does not restart spacing; edge at 4 accepted
        base = hi_total;
        b_edge(); b_edge(); b_edge(); tick(40);
        chk("R8", hi_total - base, 14);

        // R9: zero width suppresses
        cur_tag = "R9"; width = 16'd0; base = hi_total;
        b_edge(); tick(20);
        chk("R9", hi_total - base, 0);
        // R9: width sampled at accept only
        width = 16'd3; base = hi_total;
        pin_b = 1'b1; tick(1); pin_b = 1'b0; tick(3);
        width = 16'd9; tick(30);
        chk("R9", hi_total - base, 3);
        // R9: zero-width retrigger 5 cycles in ends the pulse
        width = 16'd8; base = hi_total;
        b_edge(); tick(3); width = 16'd0; b_edge(); tick(30);
        chk("R9", hi_total - base, 5);

        // R4: clear mid-pulse, edges during clear ignored
        cur_tag = "R4"; width = 16'd20; base = hi_total;
        pin_b = 1'b1; tick(1); pin_b = 1'b0; tick(4);
        pin_rd = 1'b0; tick(2);
        b_edge(); b_edge(); tick(1);
        pin_rd = 1'b1; tick(30);
        chk("R4", hi_total - base, 5);

        // R10: non-trigger changes during a pulse
        cur_tag = "R10"; width = 16'd12; base = hi_total;
        pin_b = 1'b1; tick(2); pin_a = 1'b1; tick(1);
        pin_b = 1'b0; tick(1); pin_a = 1'b0; tick(40);
        chk("R10", hi_total - base, 12);
        // R10: trigger-enabling levels held static give one pulse only
        width = 16'd6; base = hi_total;
        pin_b = 1'b1; tick(40);
        chk("R10", hi_total - base, 6);
        pin_b = 1'b0; tick(5);

        // R7: continuous retrigger every 6 cycles, 10 times: 54 + 8
        cur_tag = "R7"; width = 16'd8; base = hi_total;
        for (int i = 0; i < 10; i++) begin
            b_edge(); tick(4);
        end
        tick(30);
        chk("R7", hi_total - base, 62);

        // R12: synchronous reset mid-pulse with clear high
        cur_tag = "R12"; width = 16'd30; base = hi_total;
        b_edge(); tick(3);
        rst = 1'b1; tick(2); rst = 1'b0; tick(30);
        chk("R12", hi_total - base, 3);

        done = 1'b1;
        finish_run();
    end

endmodule